// File: doc/BRIEF.md
# Sticky Alarm Interrupt Aggregator

This block gathers six live alarm conditions, three per link direction (reference loss, signal loss and lock loss, for receive and for transmit). It brings them into its clock domain and, on each pulse of a slow sampling strobe, latches any active one into a sticky status bit. Software clears a sticky bit by writing a one to it. Each sticky bit has its own mask bit. The masked sticky bits are combined into one active-low interrupt request.

A small register port gives software access to the synchronized live alarms, the sticky bits, the masks and a global enable. The global enable gates sticky capture. Receive and transmit use separate register banks that share the same bit layout: bit 6 is reference loss, bit 5 is signal loss and bit 4 is lock loss. The alarm input vector `alarm_in` is ordered with index 0 = rx lock, 1 = rx signal, 2 = rx reference, 3 = tx lock, 4 = tx signal, 5 = tx reference.

Top module: `alarm_irq_agg`

## Requirements
- R1: After reset, the sticky bits, the masks and the global enable are all zero, and `irq_n` is high.
- R2: Live status reads at address 9 (receive) and address 137 (transmit) return the alarm inputs in bits 6:4 (reference, signal, lock). The value is taken after a two-flop synchronizer. All other bits read zero.
- R3: When the enable is set, an alarm held active sets its sticky bit within SAMPLE_DIV+3 clocks. The bit stays set after the alarm goes away.
- R4: When the enable is clear, no sticky bit is set, whatever the alarm inputs do.
- R5: Sticky bits read at address 5 (receive) and address 133 (transmit), in bits 6:4. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R6: If an alarm is still active, a cleared sticky bit sets again on the next sampling strobe. When a set and a clear fall in the same cycle, the set wins.
- R7: The masks at address 4 (receive) and address 132 (transmit) are read/write in bits 6:4. A mask value of 1 enables its source. `irq_n` is low exactly when some sticky bit and its mask are both 1.
- R8: A mask value of 0 does not stop the sticky bit from being set. It only keeps that bit off `irq_n`.
- R9: The global enable is read/write at address 2, bit 5. Other bits at that address read zero.
- R10: A read strobe returns `rd_data` with `rd_valid` high on the following clock. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_in | input | 6 | Live alarm conditions, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Each result has its own latency. Read data is due one clock after the read strobe. A live alarm reaches its status register two clocks after the input changes. A sticky bit sets at the first sampling strobe after that, which is at most SAMPLE_DIV clocks later. `irq_n` follows a mask or clear write combinationally, from the edge that commits the write. The bench changes alarms at a falling edge and then waits SAMPLE_DIV+6 clocks before reading back, so every sampling phase is covered. A monitor takes each read result from a queue on the falling edge after `rd_valid` rises. `irq_n` is checked one falling edge after the write that affects it.

// File: rtl/alarm_irq_agg.sv
module alarm_irq_agg #(
  parameter int SAMPLE_DIV = 20,
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    alarm_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq_n
);
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [AW-1:0] A_GEN    = AW'(2);
  localparam logic [AW-1:0] A_RXMASK = AW'(4);
  localparam logic [AW-1:0] A_RXSTK  = AW'(5);
  localparam logic [AW-1:0] A_RXLIVE = AW'(9);
  localparam logic [AW-1:0] A_TXMASK = AW'(132);
  localparam logic [AW-1:0] A_TXSTK  = AW'(133);
  localparam logic [AW-1:0] A_TXLIVE = AW'(137);
  localparam int FLD = 4;
  localparam int GEN_BIT = 5;

  logic [5:0] sync1, live;
  logic [5:0] sticky, mask, clr, set;
  logic gen_en;
  logic [CW-1:0] cnt;
  logic tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      live  <= '0;
    end else begin
      sync1 <= alarm_in;
      live  <= sync1;
    end

  assign tick = (cnt == CW'(SAMPLE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;

  assign clr[2:0] = (wr_en && addr == A_RXSTK) ? wr_data[FLD+2:FLD] : 3'b000;
  assign clr[5:3] = (wr_en && addr == A_TXSTK) ? wr_data[FLD+2:FLD] : 3'b000;
  assign set      = (tick && gen_en) ? live : 6'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask   <= '0;
      gen_en <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_RXMASK) mask[2:0] <= wr_data[FLD+2:FLD];
      if (addr == A_TXMASK) mask[5:3] <= wr_data[FLD+2:FLD];
      if (addr == A_GEN)    gen_en    <= wr_data[GEN_BIT];
    end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_GEN:    rd_mux[GEN_BIT] = gen_en;
      A_RXMASK: rd_mux[FLD+2:FLD] = mask[2:0];
      A_RXSTK:  rd_mux[FLD+2:FLD] = sticky[2:0];
      A_RXLIVE: rd_mux[FLD+2:FLD] = live[2:0];
      A_TXMASK: rd_mux[FLD+2:FLD] = mask[5:3];
      A_TXSTK:  rd_mux[FLD+2:FLD] = sticky[5:3];
      A_TXLIVE: rd_mux[FLD+2:FLD] = live[5:3];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end

  assign irq_n = ~|(sticky & mask);

  a_r3_set_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky & ~$past(sticky))) |-> $past(tick));

  a_r4_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> ((sticky & ~$past(sticky)) == 6'b0));

  a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sticky) & ~sticky)) |-> $past(wr_en));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gen_en && |live) |=> |sticky);

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 6'b0) |-> irq_n);
endmodule

// File: tb/alarm_irq_agg_test.sv
module alarm_irq_agg_test;
  localparam int DIV = 20;
  localparam int SETTLE = DIV + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] alarm_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid, irq_n;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  alarm_irq_agg #(.SAMPLE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n)
  );

  always @(negedge clk) if (rst_n && rd_valid) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected rd_valid actual %02h expected none", rd_data);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s read actual %02h expected %02h", t, rd_data, e);
      end
    end
  end

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, logic [7:0] e, string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(logic e, string t);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s irq_n actual %0b expected %0b", t, irq_n, e);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    chk_irq(1'b1, "R1");
    do_read(8'd2, 8'h00, "R1");
    do_read(8'd4, 8'h00, "R1");
    do_read(8'd5, 8'h00, "R1");
    do_read(8'd132, 8'h00, "R1");
    do_read(8'd133, 8'h00, "R1");

    // R4: rx reference loss with capture disabled
    alarm_in = 6'b000100;
    wait_clks(2 * SETTLE);
    do_read(8'd9, 8'h40, "R2");
    do_read(8'd5, 8'h00, "R4");

    // R9
    do_write(8'd2, 8'hFF);
    do_read(8'd2, 8'h20, "R9");
    wait_clks(SETTLE);
    do_read(8'd5, 8'h40, "R3");
    chk_irq(1'b1, "R8");
    do_write(8'd4, 8'hFF);
    do_read(8'd4, 8'h70, "R7");
    chk_irq(1'b0, "R7");

    alarm_in = 6'b000000;
    wait_clks(SETTLE);
    do_read(8'd9, 8'h00, "R2");
    do_read(8'd5, 8'h40, "R3");
    do_write(8'd5, 8'h00);
    do_read(8'd5, 8'h40, "R5");
    do_write(8'd5, 8'h40);
    do_read(8'd5, 8'h00, "R5");
    chk_irq(1'b1, "R7");

    // transmit lock and signal loss
    alarm_in = 6'b011000;
    wait_clks(SETTLE);
    do_read(8'd137, 8'h30, "R2");
    do_read(8'd133, 8'h30, "R3");
    do_read(8'd5, 8'h00, "R3");
    chk_irq(1'b1, "R8");
    do_write(8'd132, 8'h10);
    do_read(8'd132, 8'h10, "R7");
    chk_irq(1'b0, "R7");
    do_write(8'd133, 8'h10);
    wait_clks(SETTLE);
    do_read(8'd133, 8'h30, "R6");
    chk_irq(1'b0, "R6");

    alarm_in = 6'b000000;
    wait_clks(SETTLE);
    do_write(8'd133, 8'h30);
    do_read(8'd133, 8'h00, "R5");
    chk_irq(1'b1, "R7");

    alarm_in = 6'b111111;
    wait_clks(SETTLE);
    do_read(8'd9, 8'h70, "R2");
    do_read(8'd137, 8'h70, "R2");
    do_read(8'd3, 8'h00, "R10");
    do_write(8'd2, 8'h00);
    do_read(8'd2, 8'h00, "R9");

    wait_clks(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending reads actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule